// File: doc/BRIEF.md
# Universal Shift Register with Asynchronous Load and Clear

This block is an N-bit universal shift register (4 bits by default) built from identical one-bit stages. On each rising clock edge a two-bit mode input selects one of four clocked actions for every stage: keep its value, take the bit from the stage above (shift right), take the bit from the stage below (shift left), or copy its own parallel data bit. The end stages take the serial inputs in place of the missing neighbour. Counting the value of the bit that enters a shift, the clocked actions fall into six kinds: hold, shift left with 0 or with 1 entering, shift right with 0 or with 1 entering, and parallel load.

Each stage's flip-flop also has asynchronous set and reset overrides. While the active-low load input is asserted, a stage whose data bit is 1 has its set override asserted, and a stage whose data bit is 0 has its reset override asserted. The register therefore follows the parallel data with no clock edge. The active-low clear input asserts every reset override and blocks every set override. Clear therefore beats load. While either override is in force, clock edges have no effect. Clocked operation resumes on the first rising edge after both inputs are released.

A wider register is made by setting the width parameter. An 8-bit instance behaves exactly like two 4-bit sections that share every control input and pass their serial bits to each other.

Top module: `ushift_reg`

## Requirements
- R1: While `clear_n` is 0, every bit of `q` is 0 without waiting for a clock edge, whatever `load_n`, `par_data` and `mode_sel` are.
- R2: While `load_n` is 0 and `clear_n` is 1, `q` equals `par_data` without a clock edge, and follows changes of `par_data` while load stays asserted.
- R3: When `clear_n` and `load_n` are both 0, `q` is 0. On release of `clear_n` alone, `q` becomes `par_data`.
- R4: Rising clock edges that arrive while `clear_n` or `load_n` is 0 do not move `q` away from its forced value, for any `mode_sel`.
- R5: `mode_sel` = 2'b00 (hold) leaves `q` unchanged at the rising edge.
- R6: `mode_sel` = 2'b01 (shift right) at the rising edge sets `q[i]` to the old `q[i+1]` and `q[WIDTH-1]` to `ser_right_in`, with 0 and with 1 entering.
- R7: `mode_sel` = 2'b10 (shift left) at the rising edge sets `q[i]` to the old `q[i-1]` and `q[0]` to `ser_left_in`, with 0 and with 1 entering.
- R8: `mode_sel` = 2'b11 (synchronous load) copies `par_data` into `q` at the rising edge.
- R9: A value forced by a load pulse that starts and ends between two clock edges stays in `q` after the pulse. The next edge acts on it as the mode selects.
- R10: A `WIDTH`=8 instance produces the same output as two `WIDTH`=4 sections in which the upper section's bit 0 feeds the lower section's shift-right input, and the lower section's bit 3 feeds the upper section's shift-left input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; clocked actions take place on the rising edge |
| mode_sel | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 synchronous load |
| ser_right_in | input | 1 | Bit that enters the MSB on a right shift |
| ser_left_in | input | 1 | Bit that enters the LSB on a left shift |
| par_data | input | WIDTH | Parallel data for both the synchronous and the asynchronous load |
| load_n | input | 1 | Active-low asynchronous load |
| clear_n | input | 1 | Active-low asynchronous clear; takes precedence over load |
| q | output | WIDTH | Register contents |

## Verification
The bench targets load and clear pulses that begin and end between two clock edges. A design that clocked its load would miss the pulse, and a design whose override released into the wrong value would lose the data before the next edge. It holds clear and load together and then releases clear alone, which exposes a set override that is not gated by clear or a reset that outranks nothing. It also keeps load or clear asserted across edges with shift modes selected, so that a flip-flop that lets the clock through under an override shows a moved bit. Finally, an 8-bit register runs next to two chained 4-bit sections under random traffic, which catches a wrong end-stage serial hookup or a reversed shift direction.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Clocked action chosen by the two-bit mode input.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_SLOAD = 2'b11
    } usr_mode_e;

    // Which asynchronous override currently owns the flip-flops.
    typedef enum logic [1:0] {
        OVR_NONE  = 2'b00,
        OVR_LOAD  = 2'b01,
        OVR_CLEAR = 2'b10
    } usr_ovr_e;

endpackage

// File: rtl/usr_override.sv
module usr_override
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             load_n,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] force_set,
    output logic [WIDTH-1:0] force_rst
);

    usr_ovr_e ovr_state;

    // Decode the override owner; clear outranks load.
    always_comb begin
        if (!clear_n)     ovr_state = OVR_CLEAR;
        else if (!load_n) ovr_state = OVR_LOAD;
        else              ovr_state = OVR_NONE;
    end

    // Per-bit set/reset drive: set only under load with data 1,
    // reset under clear or under load with data 0.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (ovr_state)
                OVR_CLEAR: begin
                    force_set[i] = 1'b0;
                    force_rst[i] = 1'b1;
                end
                OVR_LOAD: begin
                    force_set[i] = par_data[i];
                    force_rst[i] = ~par_data[i];
                end
                default: begin
                    force_set[i] = 1'b0;
                    force_rst[i] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/usr_stage.sv
module usr_stage
    import usr_pkg::*;
(
    input  logic      clk,
    input  usr_mode_e mode,
    input  logic      from_hi,
    input  logic      from_lo,
    input  logic      par_bit,
    input  logic      force_set,
    input  logic      force_rst,
    output logic      bit_q
);

    logic nxt;

    // Next-state selection for this bit.
    always_comb begin
        unique case (mode)
            MODE_HOLD:  nxt = bit_q;
            MODE_SHR:   nxt = from_hi;
            MODE_SHL:   nxt = from_lo;
            MODE_SLOAD: nxt = par_bit;
            default:    nxt = bit_q;
        endcase
    end

    // Storage with asynchronous reset and set; reset wins.
    always_ff @(posedge clk or posedge force_rst or posedge force_set) begin
        if (force_rst)      bit_q <= 1'b0;
        else if (force_set) bit_q <= 1'b1;
        else                bit_q <= nxt;
    end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [1:0]       mode_sel,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic [WIDTH-1:0] par_data,
    input  logic             load_n,
    input  logic             clear_n,
    output logic [WIDTH-1:0] q
);

    localparam int EXT_W = WIDTH + 2;

    usr_mode_e        mode;
    logic [WIDTH-1:0] force_set;
    logic [WIDTH-1:0] force_rst;
    logic [WIDTH-1:0] q_int;
    logic [EXT_W-1:0] chain;

    assign mode = usr_mode_e'(mode_sel);

    // Neighbour vector: serial right input above the MSB, serial left below the LSB.
    assign chain = {ser_right_in, q_int, ser_left_in};

    usr_override #(.WIDTH(WIDTH)) u_ovr (
        .load_n    (load_n),
        .clear_n   (clear_n),
        .par_data  (par_data),
        .force_set (force_set),
        .force_rst (force_rst)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        usr_stage u_stage (
            .clk       (clk),
            .mode      (mode),
            .from_hi   (chain[i+2]),
            .from_lo   (chain[i]),
            .par_bit   (par_data[i]),
            .force_set (force_set[i]),
            .force_rst (force_rst[i]),
            .bit_q     (q_int[i])
        );
    end

    assign q = q_int;

endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic [1:0]       mode_sel,
    input logic             ser_right_in,
    input logic             ser_left_in,
    input logic [WIDTH-1:0] par_data,
    input logic             load_n,
    input logic             clear_n,
    input logic [WIDTH-1:0] q
);

    // High from any override activity until the next clock edge after release.
    logic async_seen;
    always_ff @(posedge clk or negedge load_n or negedge clear_n) begin
        if (!load_n || !clear_n) async_seen <= 1'b1;
        else                     async_seen <= 1'b0;
    end

    // Level checks of the overrides, taken mid-cycle.
    always @(negedge clk) begin
        if (!clear_n) begin
            assert_clear_zero_R1: assert (q == '0);
            if (!load_n) begin
                assert_clear_beats_load_R3: assert (q == '0);
            end
        end else if (!load_n) begin
            assert_load_follows_R2: assert (q == par_data);
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!clear_n || !load_n)
        (!async_seen && $past(mode_sel) == 2'b00) |-> q == $past(q));

    assert_shr_R6: assert property (@(posedge clk) disable iff (!clear_n || !load_n)
        (!async_seen && $past(mode_sel) == 2'b01)
        |-> q == {$past(ser_right_in), $past(q[WIDTH-1:1])});

    assert_shl_R7: assert property (@(posedge clk) disable iff (!clear_n || !load_n)
        (!async_seen && $past(mode_sel) == 2'b10)
        |-> q == {$past(q[WIDTH-2:0]), $past(ser_left_in)});

    assert_sload_R8: assert property (@(posedge clk) disable iff (!clear_n || !load_n)
        (!async_seen && $past(mode_sel) == 2'b11) |-> q == $past(par_data));

endmodule

bind ushift_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .mode_sel     (mode_sel),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .par_data     (par_data),
    .load_n       (load_n),
    .clear_n      (clear_n),
    .q            (q)
);

// File: tb/tb_ushift_reg.sv
`timescale 1ns/1ps
module tb_ushift_reg;

    logic       clk = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       sr = 1'b0;
    logic       sl = 1'b0;
    logic [7:0] data = 8'h00;
    logic       load_n = 1'b1;
    logic       clear_n = 1'b0;
    logic [3:0] q4;
    logic [7:0] q8;
    logic [3:0] q_lo;
    logic [3:0] q_hi;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m4;
    logic [7:0] m8;

    always #2.5 clk = ~clk;

    ushift_reg dut (
        .clk(clk), .mode_sel(mode_sel), .ser_right_in(sr), .ser_left_in(sl),
        .par_data(data[3:0]), .load_n(load_n), .clear_n(clear_n), .q(q4));

    ushift_reg #(.WIDTH(8)) wide (
        .clk(clk), .mode_sel(mode_sel), .ser_right_in(sr), .ser_left_in(sl),
        .par_data(data), .load_n(load_n), .clear_n(clear_n), .q(q8));

    ushift_reg sec_hi (
        .clk(clk), .mode_sel(mode_sel), .ser_right_in(sr), .ser_left_in(q_lo[3]),
        .par_data(data[7:4]), .load_n(load_n), .clear_n(clear_n), .q(q_hi));

    ushift_reg sec_lo (
        .clk(clk), .mode_sel(mode_sel), .ser_right_in(q_hi[0]), .ser_left_in(sl),
        .par_data(data[3:0]), .load_n(load_n), .clear_n(clear_n), .q(q_lo));

    function automatic logic [7:0] model_next(input logic [7:0] cur, input int w,
            input logic [1:0] md, input logic r_in, input logic l_in, input logic [7:0] d);
        logic [7:0] mask;
        mask = 8'((16'd1 << w) - 16'd1);
        case (md)
            2'b00:   return cur;
            2'b01:   return ((cur & mask) >> 1) | (8'(r_in) << (w - 1));
            2'b10:   return ((cur << 1) | 8'(l_in)) & mask;
            default: return d & mask;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, {4'h0, q4}, {4'h0, m4});
        chk(req, q8, m8);
        chk("R10", {q_hi, q_lo}, q8);
    endtask

    // Apply async effect of current override inputs to the model.
    task automatic model_async();
        if (!clear_n) begin
            m4 = '0; m8 = '0;
        end else if (!load_n) begin
            m4 = data[3:0]; m8 = data;
        end
    endtask

    // One clock cycle: drive after the falling edge, check after the rising edge.
    task automatic cycle(input logic [1:0] md, input logic r_in, input logic l_in,
            input logic [7:0] d, input logic ld, input logic cl, input string req);
        @(negedge clk); #0.2;
        mode_sel = md; sr = r_in; sl = l_in; data = d; load_n = ld; clear_n = cl;
        model_async();
        @(posedge clk);
        if (load_n && clear_n) begin
            m4 = model_next({4'h0, m4}, 4, md, r_in, l_in, d)[3:0];
            m8 = model_next(m8, 8, md, r_in, l_in, d);
        end
        #0.5;
        check_all(req);
    endtask

    // Override pulse that begins and ends between two edges (mode left at hold).
    task automatic pulse(input logic [7:0] d, input logic use_clear, input string req);
        @(negedge clk); #0.2;
        mode_sel = 2'b00; data = d;
        if (use_clear) clear_n = 1'b0; else load_n = 1'b0;
        #0.5;
        model_async();
        check_all(req);
        load_n = 1'b1; clear_n = 1'b1;
        #0.3;
        check_all("R9");
    endtask

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m4 = '0; m8 = '0;
        #1;
        check_all("R1");                             // reset state under clear
        cycle(2'b01, 1, 1, 8'hFF, 1, 0, "R4");       // edge under clear: stays 0
        cycle(2'b11, 0, 0, 8'hA5, 1, 1, "R8");       // sync load
        cycle(2'b00, 1, 1, 8'h00, 1, 1, "R5");       // hold
        cycle(2'b01, 1, 0, 8'h00, 1, 1, "R6");       // shift right, 1 enters
        cycle(2'b01, 0, 0, 8'h00, 1, 1, "R6");       // shift right, 0 enters
        cycle(2'b10, 0, 1, 8'h00, 1, 1, "R7");       // shift left, 1 enters
        cycle(2'b10, 0, 0, 8'h00, 1, 1, "R7");       // shift left, 0 enters
        pulse(8'h3C, 1'b0, "R2");                    // async load between edges
        cycle(2'b10, 0, 1, 8'h00, 1, 1, "R9");       // next edge acts on loaded value
        pulse(8'hFF, 1'b1, "R1");                    // async clear between edges
        // Load and clear together, then release clear alone.
        @(negedge clk); #0.2;
        data = 8'hF0; load_n = 1'b0; clear_n = 1'b0; mode_sel = 2'b01;
        #0.5; model_async(); check_all("R3");
        clear_n = 1'b1; #0.5; model_async(); check_all("R3");
        data = 8'h69; #0.5; model_async(); check_all("R2");
        cycle(2'b10, 1, 1, 8'h96, 0, 1, "R4");       // edge under load
        cycle(2'b11, 1, 1, 8'h5A, 1, 1, "R8");
        for (int k = 0; k < 400; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            if (r == 0)
                pulse(8'($urandom), 1'($urandom), "R2");
            else
                cycle(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                      (r != 1), (r != 2), "R10");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule